// File: doc/BRIEF.md
# Secure Mode Key Store

This block holds a small set of fixed-width encryption keys behind a two-state security mode. After reset it is in secure mode. In that mode the command port may load keys, but any attempt to read one back returns zeros and leaves a sticky mark. The cipher engine next to the block always sees the stored keys on its own lookup port. It never reaches the command port.

A single command port stands in for a test-access port. It carries a valid strobe, a two-bit opcode, an entry index and a key word. It offers four commands: load an entry, read an entry, enter secure mode and leave secure mode. Leaving secure mode first runs a wipe sequence that clears one entry per clock. During the wipe, busy is raised and every command is dropped. When the wipe finishes, the mode turns non-secure and a one-cycle configuration-clear strobe is issued. Entering secure mode from non-secure mode leaves the keys as they are.

Top module: `keystore_guard`

## Requirements
- R1: There are six entries of 56 bits. In non-secure mode, a read (opcode 1) of entry i returns the value last loaded (opcode 0) into entry i. rdValid is high for one cycle in the cycle after the command is accepted.
- R2: After reset, secureMode is 1, and busy, cfgClear, violation and rdValid are 0. Every entry reads as zero.
- R3: In secure mode, a read returns rdValid with rdKey equal to zero and sets violation.
- R4: In secure mode, load commands are accepted and the loaded value is visible on the engine port.
- R5: A leave-secure command (opcode 3) issued in secure mode raises busy for exactly six cycles, starting in the cycle after it is accepted. All entries become zero. In the cycle after busy falls, secureMode is 0 and cfgClear is high for that one cycle only.
- R6: An enter-secure command (opcode 2) issued in non-secure mode sets secureMode in the next cycle. It raises neither busy nor cfgClear and leaves every entry unchanged.
- R7: Entry indices 6 and 7 are invalid. Loads to them are dropped, and reads of them (and engine lookups) return zero.
- R8: violation stays set until reset. Reads in non-secure mode do not set it.
- R9: A leave-secure command in non-secure mode has no effect: no busy, no cfgClear, keys kept. An enter-secure command in secure mode also has no effect.
- R10: engKey shows the entry selected by engIdx in either mode, without delay.
- R11: Commands presented while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe; accepted when busy is low |
| cmdOp | input | 2 | 0 load, 1 read, 2 enter secure, 3 leave secure |
| cmdIdx | input | 3 | Entry index |
| cmdKey | input | 56 | Key word for a load |
| rdValid | output | 1 | Read result valid |
| rdKey | output | 56 | Read result |
| secureMode | output | 1 | 1 while in secure mode |
| busy | output | 1 | Wipe in progress |
| cfgClear | output | 1 | One-cycle configuration-clear strobe |
| violation | output | 1 | Sticky secure-read attempt flag |
| engIdx | input | 3 | Engine lookup index |
| engKey | output | 56 | Engine lookup key |

## Verification
A wrong mode bit shows up at once: in the cycle after a read, rdKey carries key data it should hide, or zeros where a key was expected. A wipe counter that stops early or late shows as a busy window other than six cycles. It also shows as a leftover nonzero entry, which is visible on the engine port and on later reads. A lost or doubled clear strobe is visible on cfgClear in the cycle busy falls.

// File: rtl/keystore_pkg.sv
package keystore_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_READ   = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } cmd_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WIPE = 1'b1
  } ks_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // load entry addressed by command index
    logic rdEn;     // capture a read result
    logic rdAllow;  // key data may leave the block
    logic clrEn;    // zero the entry addressed by wipe index
  } ks_strobe_t;
endpackage

// File: rtl/keystore_ctrl.sv
module keystore_ctrl
  import keystore_pkg::*;
#(
  parameter int NUM_KEYS = 6,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdIdx,
  output ks_strobe_t       strb,
  output logic [IDX_W-1:0] clrIdx,
  output logic             secureMode,
  output logic             busy,
  output logic             cfgClear,
  output logic             violation
);
  localparam logic [IDX_W:0]   NUM_EXT  = (IDX_W+1)'(NUM_KEYS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_KEYS - 1);

  ks_state_e        stateQ;
  logic             secureQ;
  logic [IDX_W-1:0] wipeIdxQ;
  logic             cfgClearQ;
  logic             violQ;
  cmd_op_e          op;
  logic             accept;
  logic             idxValid;

  assign op       = cmd_op_e'(cmdOp);
  assign accept   = cmdValid && (stateQ == ST_IDLE);
  assign idxValid = {1'b0, cmdIdx} < NUM_EXT;

  always_comb begin
    strb.wrEn    = accept && (op == OP_WRITE) && idxValid;
    strb.rdEn    = accept && (op == OP_READ);
    strb.rdAllow = !secureQ;
    strb.clrEn   = (stateQ == ST_WIPE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      secureQ   <= 1'b1;
      wipeIdxQ  <= '0;
      cfgClearQ <= 1'b0;
      violQ     <= 1'b0;
    end else begin
      cfgClearQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            case (op)
              OP_READ:   if (secureQ) violQ <= 1'b1;
              OP_LOCK:   secureQ <= 1'b1;
              OP_UNLOCK: if (secureQ) begin
                stateQ   <= ST_WIPE;
                wipeIdxQ <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_WIPE: begin
          if (wipeIdxQ == LAST_IDX) begin
            stateQ    <= ST_IDLE;
            secureQ   <= 1'b0;
            cfgClearQ <= 1'b1;
          end else begin
            wipeIdxQ <= wipeIdxQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign clrIdx     = wipeIdxQ;
  assign secureMode = secureQ;
  assign busy       = (stateQ == ST_WIPE);
  assign cfgClear   = cfgClearQ;
  assign violation  = violQ;

  // R5: the clear strobe lasts one cycle
  assert_clear_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgClear |=> !cfgClear);
  // R5: mode drops out of secure only together with the clear strobe
  assert_unlock_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(secureMode) |-> cfgClear);
  // R5: a wipe ends only through the clear strobe
  assert_wipe_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || cfgClear));
  // R11: mode stays secure throughout the wipe
  assert_busy_secure_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> secureMode);
  // R8: violation is sticky
  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);
endmodule

// File: rtl/keystore_dp.sv
module keystore_dp
  import keystore_pkg::*;
#(
  parameter int NUM_KEYS = 6,
  parameter int KEY_W    = 56,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ks_strobe_t       strb,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [KEY_W-1:0] cmdKey,
  input  logic [IDX_W-1:0] clrIdx,
  input  logic [IDX_W-1:0] engIdx,
  output logic             rdValid,
  output logic [KEY_W-1:0] rdKey,
  output logic [KEY_W-1:0] engKey
);
  logic [KEY_W-1:0] keyQ [NUM_KEYS];
  logic [KEY_W-1:0] cmdSel;
  logic             rdValidQ;
  logic [KEY_W-1:0] rdKeyQ;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        keyQ[g] <= '0;
      else if (strb.clrEn && (clrIdx == IDX_W'(g)))
        keyQ[g] <= '0;
      else if (strb.wrEn && (cmdIdx == IDX_W'(g)))
        keyQ[g] <= cmdKey;
    end

    // R5: a wiped entry holds zero afterwards
    assert_entry_wiped_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrEn && (clrIdx == IDX_W'(g))) |=> (keyQ[g] == '0));
  end

  // Index selects; an index with no entry yields zero
  always_comb begin
    cmdSel = '0;
    engKey = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (cmdIdx == IDX_W'(i)) cmdSel = keyQ[i];
      if (engIdx == IDX_W'(i)) engKey = keyQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdKeyQ   <= '0;
    end else begin
      rdValidQ <= strb.rdEn;
      if (strb.rdEn) rdKeyQ <= strb.rdAllow ? cmdSel : '0;
    end
  end

  assign rdValid = rdValidQ;
  assign rdKey   = rdKeyQ;

  // R3: a read captured while key data was withheld carries zeros
  assert_hidden_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !$past(strb.rdAllow)) |-> (rdKey == '0));
endmodule

// File: rtl/keystore_guard.sv
module keystore_guard
  import keystore_pkg::*;
#(
  parameter int NUM_KEYS = 6,
  parameter int KEY_W    = 56,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [KEY_W-1:0] cmdKey,
  output logic             rdValid,
  output logic [KEY_W-1:0] rdKey,
  output logic             secureMode,
  output logic             busy,
  output logic             cfgClear,
  output logic             violation,
  input  logic [IDX_W-1:0] engIdx,
  output logic [KEY_W-1:0] engKey
);
  ks_strobe_t       strb;
  logic [IDX_W-1:0] clrIdx;

  keystore_ctrl #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .strb(strb), .clrIdx(clrIdx),
    .secureMode(secureMode), .busy(busy), .cfgClear(cfgClear),
    .violation(violation)
  );

  keystore_dp #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIdx(cmdIdx), .cmdKey(cmdKey),
    .clrIdx(clrIdx), .engIdx(engIdx), .rdValid(rdValid), .rdKey(rdKey),
    .engKey(engKey)
  );
endmodule

// File: tb/tb_keystore_guard.sv
module tb_keystore_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [2:0]  cmdIdx = 3'd0;
  logic [55:0] cmdKey = '0;
  logic        rdValid, secureMode, busy, cfgClear, violation;
  logic [55:0] rdKey, engKey;
  logic [2:0]  engIdx = 3'd0;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [55:0] mdl [8];
  bit          mdlSecure;
  logic [55:0] expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  keystore_guard dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .cmdKey(cmdKey), .rdValid(rdValid), .rdKey(rdKey),
    .secureMode(secureMode), .busy(busy), .cfgClear(cfgClear),
    .violation(violation), .engIdx(engIdx), .engKey(engKey)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] pat(int i, int s);
    return {8'(i + 1), 8'(s), 40'hC3_5A_96_0F_E1} ^ {48'd0, 8'(i * 37 + s)};
  endfunction

  // Monitor: compare each read result with the scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk("R1 unexpected read", 64'(rdKey), 64'hDEAD);
      end else begin
        automatic logic [55:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(t, 64'(rdKey), 64'(e));
      end
    end
  end

  // Driver: one command, expected read pushed into the scoreboard
  task automatic issue(logic [1:0] op, int idx, logic [55:0] key, string tag);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIdx = 3'(idx); cmdKey = key;
    if (op == 2'd0 && idx < 6) mdl[idx] = key;
    if (op == 2'd1) begin
      expQ.push_back((!mdlSecure && idx < 6) ? mdl[idx] : 56'd0);
      tagQ.push_back(tag);
    end
    if (op == 2'd2) mdlSecure = 1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic unlock(bit injectWrite);
    int cnt = 0;
    bit wasSecure = mdlSecure;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd3; cmdIdx = 3'd0;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy && cnt < 20) begin
      cnt++;
      if (!secureMode) chk("R11 secure during wipe", 0, 1);
      cmdValid = injectWrite && (cnt == 2);
      cmdOp = 2'd0; cmdIdx = 3'd0; cmdKey = 56'hFF_FFFF_FFFF_FFFF;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    if (wasSecure) begin
      chk("R5 busy cycles", cnt, 6);
      chk("R5 clear pulse", 64'(cfgClear), 1);
      chk("R5 mode non-secure", 64'(secureMode), 0);
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      mdlSecure = 0;
    end else begin
      chk("R9 no wipe busy", cnt, 0);
      chk("R9 no clear pulse", 64'(cfgClear), 0);
    end
    @(negedge clk);
    chk("R5 clear one cycle", 64'(cfgClear), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    mdlSecure = 1;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 secureMode", 64'(secureMode), 1);
    chk("R2 busy", 64'(busy), 0);
    chk("R2 cfgClear", 64'(cfgClear), 0);
    chk("R2 violation", 64'(violation), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 rdValid", 64'(rdValid), 0);
    engIdx = 3'd0; #1 chk("R2 entry zero", 64'(engKey), 0);

    // R4: loads in secure mode reach the engine port
    for (int i = 0; i < 6; i++) issue(2'd0, i, pat(i, 1), "R4");
    engIdx = 3'd3; #1 chk("R4 engine sees load", 64'(engKey), 64'(pat(3, 1)));
    engIdx = 3'd5; #1 chk("R10 engine in secure", 64'(engKey), 64'(pat(5, 1)));

    // R3: secure read hidden, violation set
    issue(2'd1, 2, '0, "R3 secure read zero");
    chk("R3 violation set", 64'(violation), 1);

    // R5, R11: wipe with an ignored load in the middle
    unlock(1'b1);
    for (int i = 0; i < 6; i++) issue(2'd1, i, '0, "R5 R11 entry wiped");
    engIdx = 3'd0; #1 chk("R11 load during busy dropped", 64'(engKey), 0);
    chk("R8 violation kept", 64'(violation), 1);

    // R1: load and read back in non-secure mode
    for (int i = 0; i < 6; i++) issue(2'd0, i, pat(i, 2), "R1");
    for (int i = 5; i >= 0; i--) issue(2'd1, i, '0, "R1 readback");
    issue(2'd0, 2, pat(2, 9), "R1");
    issue(2'd1, 2, '0, "R1 overwrite");

    // R7: invalid indices
    issue(2'd0, 6, pat(6, 3), "R7");
    issue(2'd0, 7, pat(7, 3), "R7");
    issue(2'd1, 6, '0, "R7 read idx6 zero");
    issue(2'd1, 7, '0, "R7 read idx7 zero");
    issue(2'd1, 0, '0, "R7 no alias to entry0");
    engIdx = 3'd6; #1 chk("R7 engine idx6 zero", 64'(engKey), 0);

    // R9: leave-secure while non-secure does nothing
    unlock(1'b0);
    issue(2'd1, 4, '0, "R9 keys kept");

    // R6: enter secure keeps keys
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd2;
    @(negedge clk);
    cmdValid = 1'b0; mdlSecure = 1;
    chk("R6 secure next cycle", 64'(secureMode), 1);
    chk("R6 no busy", 64'(busy), 0);
    chk("R6 no clear", 64'(cfgClear), 0);
    engIdx = 3'd4; #1 chk("R6 key kept", 64'(engKey), 64'(pat(4, 2)));
    issue(2'd2, 0, '0, "R9");
    chk("R9 lock again no busy", 64'(busy), 0);
    issue(2'd1, 1, '0, "R3 secure read zero again");

    // R8: reset clears violation
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R8 violation reset", 64'(violation), 0);
    chk("R2 secure after reset", 64'(secureMode), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule